// File: doc/BRIEF.md
# Dual Cascadable 16-bit Timer Pair

This block holds two 16-bit general-purpose timers that share one global configuration word. Each timer has a mode word, a counter, a reference value, a capture value and a two-bit event word. A timer counts system-clock pulses, or a slow strobe at one sixteenth of the system clock, through an 8-bit prescaler. When the count reaches the reference value the timer flags a reference event. The counter then either returns to zero or keeps counting. An edge on the timer's capture pin copies the running count into the capture value and flags a capture event. Each timer has one interrupt line, and that line follows its event word through two enable bits.

A chaining option links the two timers into one 32-bit timer. Timer 2 forms the low half and timer 1 forms the high half. The high half advances whenever the low half rolls over. The combined count and the combined reference can each be written and read as a single 32-bit word. In chained mode the reference comparison uses all 32 bits, and the result is reported through timer 2's event word and interrupt.

Software reaches the registers over a simple word-addressed bus: a one-cycle write strobe and a combinational read port.

Top module: `dual_timer_pair`

## Requirements
- R1: After reset, every register reads zero and both interrupt lines are low. The register addresses are: 0 global, 1/2 mode, 3/4 count, 5/6 reference, 7/8 capture, 9/10 event (timer 1/timer 2), 11 combined count, 12 combined reference.
- R2: Global word bits: bit 0 runs timer 1, bit 4 runs timer 2, bit 7 chains the pair. The other bits read zero. While a timer's run bit is clear, its counter is held at zero and writes to it are lost.
- R3: With restart on (mode bit 0), the system clock as source and a prescale of zero, a reference of N gives a reference event (event bit 0) exactly every N clocks. The counter steps 0 to N-1.
- R4: The prescale field (mode bits 15:8) divides the selected source by field+1.
- R5: The source field (mode bits 6:5) selects: 00 the system clock, 01 one pulse per 16 clocks, 10 the chained input, 11 stopped. A stopped counter holds its value.
- R6: With restart off, a counter that reaches the reference flags the event and keeps counting, wrapping from 0xFFFF to 0.
- R7: The capture-edge field (mode bits 3:2) selects 01 rising, 10 falling, 11 both, 00 none. A selected edge copies the count into the capture register three clocks after the pin changes and sets event bit 1. Edges that are not selected change nothing.
- R8: Writing an event word clears the bits written as one and leaves the bits written as zero.
- R9: The interrupt line is high while (event bit 0 and mode bit 1) or (event bit 1 and mode bit 4) holds, and it drops once software clears the bit.
- R10: When the pair is chained, a rollover of timer 2's count advances timer 1's count. Address 11 reads the pair as {timer 1, timer 2}.
- R11: When the pair is chained, the 32-bit count is compared with the 32-bit reference. A match sets timer 2's event bit 0, drives timer 2's interrupt, and with timer 2's restart bit set clears both halves.
- R12: One write to address 11 or 12 loads both halves, with the upper 16 bits going to timer 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cap_in | input | 2 | Capture pins, bit 0 for timer 1, asynchronous |
| irq | output | 2 | Interrupt lines, bit 0 for timer 1 |

## Verification
The period measurement is repeated over a table of settings. Each row pairs a prescale value, a source and a reference so that every product of divider and reference is distinct. A swapped source, a prescaler that is off by one, or a restart that is off by one therefore gives a wrong period. Directed tests follow. One presets the counter near 0xFFFF to separate wrapping from restarting. Another drives each capture edge against each edge selection to tell selected edges from ignored ones. The last presets the chained pair just below a low-half rollover and a 32-bit match, which shows the carry, the wide compare and the clearing of both halves.

// File: rtl/tmr_pkg.sv
// Shared types and register addresses for the dual timer pair.
// Assumes a word-addressed register bus of 4 address bits and 32 data bits.
package tmr_pkg;

    localparam int REG_AW  = 4;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = 16;
    localparam int PSC_W   = 8;
    localparam int NUM_TMR = 2;
    localparam int EV_W    = 2;

    // Clock source selection held in the mode word
    typedef enum logic [1:0] {
        SRC_SYS   = 2'b00,
        SRC_SLOW  = 2'b01,
        SRC_CHAIN = 2'b10,
        SRC_STOP  = 2'b11
    } clk_src_e;

    // Mode word layout, 16 bits
    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             spare;
        clk_src_e         src;
        logic             cap_ie;
        logic [1:0]       edge_sel;
        logic             ref_ie;
        logic             restart;
    } mode_t;

    // Register addresses; timer 2 sits one word above timer 1
    localparam logic [REG_AW-1:0] ADR_GCFG     = 4'd0;
    localparam logic [REG_AW-1:0] ADR_MODE_T1  = 4'd1;
    localparam logic [REG_AW-1:0] ADR_CNT_T1   = 4'd3;
    localparam logic [REG_AW-1:0] ADR_REF_T1   = 4'd5;
    localparam logic [REG_AW-1:0] ADR_CAP_T1   = 4'd7;
    localparam logic [REG_AW-1:0] ADR_EVT_T1   = 4'd9;
    localparam logic [REG_AW-1:0] ADR_CNT_WIDE = 4'd11;
    localparam logic [REG_AW-1:0] ADR_REF_WIDE = 4'd12;

    // Global word bit positions
    localparam int GC_RUN_T1 = 0;
    localparam int GC_RUN_T2 = 4;
    localparam int GC_CHAIN  = 7;
    localparam logic [7:0] GC_MASK = 8'h91;

    // Event bit positions
    localparam int EV_REF = 0;
    localparam int EV_CAP = 1;

    // Address of a per-timer register given the timer-1 address
    function automatic logic [REG_AW-1:0] adr_of(input logic [REG_AW-1:0] base, input int idx);
        return base + REG_AW'(idx);
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
// Synchronises an asynchronous pin into the clock domain and reports
// one-cycle rising and falling pulses.
// Assumes the pin idles low out of reset; the chain resets to zero.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    logic [STAGES:0] sh_q;

    // Shift the pin through the synchroniser plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], din};
        end
    end

    // Compare the synchronised level with the previous one
    always_comb begin
        rise = sh_q[STAGES-1] & ~sh_q[STAGES];
        fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    end

endmodule

// File: rtl/tmr_prescaler.sv
// Divides a stream of source pulses by (div+1) and emits one tick per period.
// Assumes hold clears the divider whenever the owning timer is stopped.
module tmr_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         pulse,
    input  logic [W-1:0] div,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    // Tick on the pulse that completes the period
    always_comb begin
        tick = pulse && !hold && (cnt_q >= div);
    end

    // Count source pulses, wrap at the division boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else if (pulse) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_event_unit.sv
// Sticky event bits with write-one-to-clear and a masked interrupt line.
// Assumes a set and a clear of the same bit in one cycle leave the bit set.
module tmr_event_unit #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] ev,
    output logic         irq
);

    // Hold events until cleared; new events win over clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev <= '0;
        end else begin
            ev <= (ev & ~clr) | set;
        end
    end

    // Raise the line while any enabled event is pending
    always_comb begin
        irq = |(ev & ie);
    end

endmodule

// File: rtl/dual_timer_pair.sv
// Two 16-bit timers with prescalers, reference compare, edge capture and
// an option to chain them into one 32-bit timer (timer 1 = upper half).
// Assumes single-cycle bus writes and a combinational read path; capture
// pins are asynchronous and idle low at reset. Index 0 is timer 1.
module dual_timer_pair
    import tmr_pkg::*;
#(
    parameter int SLOW_LOG2  = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_TMR-1:0] cap_in,
    output logic [NUM_TMR-1:0] irq
);

    localparam int WIDE_W = 2 * HALF_W;

    logic [7:0]                         gcfg_q;
    mode_t                              mode_q [NUM_TMR];
    logic [NUM_TMR-1:0][HALF_W-1:0]     cnt_q;
    logic [NUM_TMR-1:0][HALF_W-1:0]     cnt_d;
    logic [NUM_TMR-1:0][HALF_W-1:0]     ref_q;
    logic [NUM_TMR-1:0][HALF_W-1:0]     cap_q;
    logic [NUM_TMR-1:0][EV_W-1:0]       ev_q;
    logic [NUM_TMR-1:0][EV_W-1:0]       ev_clr;
    logic [NUM_TMR-1:0][EV_W-1:0]       ev_set;
    logic [NUM_TMR-1:0]                 en;
    logic [NUM_TMR-1:0]                 tick;
    logic [NUM_TMR-1:0]                 hit;
    logic [NUM_TMR-1:0]                 cnt_ld;
    logic [NUM_TMR-1:0]                 cap_hit;
    logic [NUM_TMR-1:0]                 pin_rise;
    logic [NUM_TMR-1:0]                 pin_fall;
    logic [NUM_TMR-1:0]                 src_pulse;
    logic [NUM_TMR-1:0]                 psc_hold;
    logic [SLOW_LOG2-1:0]               slow_q;
    logic                               slow_stb;
    logic                               casc;
    logic                               gcfg_we;
    logic                               wide_cnt_we;
    logic                               wide_ref_we;
    logic [WIDE_W-1:0]                  wide_inc;
    logic                               wide_hit;

    // Decode the global word and the wide write strobes
    always_comb begin
        en[0]       = gcfg_q[GC_RUN_T1];
        en[1]       = gcfg_q[GC_RUN_T2];
        casc        = gcfg_q[GC_CHAIN];
        gcfg_we     = bus_we && (bus_addr == ADR_GCFG);
        wide_cnt_we = bus_we && (bus_addr == ADR_CNT_WIDE);
        wide_ref_we = bus_we && (bus_addr == ADR_REF_WIDE);
    end

    // Free-running divider giving one strobe every 2**SLOW_LOG2 clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q <= '0;
        end else begin
            slow_q <= slow_q + 1'b1;
        end
    end

    assign slow_stb = &slow_q;

    // Global word: only the run and chain bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg_q <= '0;
        end else if (gcfg_we) begin
            gcfg_q <= bus_wdata[7:0] & GC_MASK;
        end
    end

    // Combined 32-bit view used in chained mode
    always_comb begin
        wide_inc = {cnt_q[0], cnt_q[1]} + 1'b1;
        wide_hit = tick[1] && (wide_inc == {ref_q[0], ref_q[1]});
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
            localparam logic [REG_AW-1:0] A_MODE = adr_of(ADR_MODE_T1, gi);
            localparam logic [REG_AW-1:0] A_CNT  = adr_of(ADR_CNT_T1, gi);
            localparam logic [REG_AW-1:0] A_REF  = adr_of(ADR_REF_T1, gi);
            localparam logic [REG_AW-1:0] A_EVT  = adr_of(ADR_EVT_T1, gi);
            localparam int LO = (gi == 0) ? HALF_W : 0;

            logic [HALF_W-1:0] ld_val;

            // Mode word write; spare bit kept at zero
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mode_q[gi] <= '0;
                end else if (bus_we && bus_addr == A_MODE) begin
                    mode_q[gi]       <= mode_t'(bus_wdata[HALF_W-1:0]);
                    mode_q[gi].spare <= 1'b0;
                end
            end

            // Reference write, from the own address or the wide address
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ref_q[gi] <= '0;
                end else if (wide_ref_we) begin
                    ref_q[gi] <= bus_wdata[LO +: HALF_W];
                end else if (bus_we && bus_addr == A_REF) begin
                    ref_q[gi] <= bus_wdata[HALF_W-1:0];
                end
            end

            // Source pulse selection; the upper half in chained mode has none
            always_comb begin
                psc_hold[gi] = !en[gi] || (casc && gi == 0);
                unique case (mode_q[gi].src)
                    SRC_SYS:   src_pulse[gi] = 1'b1;
                    SRC_SLOW:  src_pulse[gi] = slow_stb;
                    SRC_CHAIN: src_pulse[gi] = 1'b0;
                    SRC_STOP:  src_pulse[gi] = 1'b0;
                    default:   src_pulse[gi] = 1'b0;
                endcase
            end

            tmr_prescaler #(.W(PSC_W)) u_psc (
                .clk   (clk),
                .rst_n (rst_n),
                .hold  (psc_hold[gi]),
                .pulse (src_pulse[gi]),
                .div   (mode_q[gi].psc),
                .tick  (tick[gi])
            );

            // Counter load strobe and value
            always_comb begin
                cnt_ld[gi] = wide_cnt_we || (bus_we && bus_addr == A_CNT);
                ld_val     = wide_cnt_we ? bus_wdata[LO +: HALF_W] : bus_wdata[HALF_W-1:0];
                hit[gi]    = tick[gi] && ((cnt_q[gi] + 1'b1) == ref_q[gi]);
            end

            // Next count: hold in reset, load, chained step or own step
            always_comb begin
                cnt_d[gi] = cnt_q[gi];
                if (!en[gi]) begin
                    cnt_d[gi] = '0;
                end else if (cnt_ld[gi]) begin
                    cnt_d[gi] = ld_val;
                end else if (casc) begin
                    if (tick[1]) begin
                        cnt_d[gi] = (wide_hit && mode_q[1].restart) ? '0 : wide_inc[LO +: HALF_W];
                    end
                end else if (tick[gi]) begin
                    cnt_d[gi] = (hit[gi] && mode_q[gi].restart) ? '0 : cnt_q[gi] + 1'b1;
                end
            end

            // Counter register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q[gi] <= '0;
                end else begin
                    cnt_q[gi] <= cnt_d[gi];
                end
            end

            tmr_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (cap_in[gi]),
                .rise  (pin_rise[gi]),
                .fall  (pin_fall[gi])
            );

            // Capture on a selected edge
            always_comb begin
                cap_hit[gi] = (mode_q[gi].edge_sel[0] && pin_rise[gi])
                           || (mode_q[gi].edge_sel[1] && pin_fall[gi]);
            end

            // Capture register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cap_q[gi] <= '0;
                end else if (cap_hit[gi]) begin
                    cap_q[gi] <= cnt_q[gi];
                end
            end

            // Event sources and write-one-to-clear mask
            always_comb begin
                ev_set[gi][EV_CAP] = cap_hit[gi];
                if (casc) begin
                    ev_set[gi][EV_REF] = (gi == 1) ? wide_hit : 1'b0;
                end else begin
                    ev_set[gi][EV_REF] = hit[gi];
                end
                ev_clr[gi] = (bus_we && bus_addr == A_EVT) ? bus_wdata[EV_W-1:0] : '0;
            end

            tmr_event_unit #(.N(EV_W)) u_evt (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (ev_set[gi]),
                .clr   (ev_clr[gi]),
                .ie    ({mode_q[gi].cap_ie, mode_q[gi].ref_ie}),
                .ev    (ev_q[gi]),
                .irq   (irq[gi])
            );
        end
    endgenerate

    // Register read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            4'd0:    bus_rdata = {24'd0, gcfg_q};
            4'd1:    bus_rdata = {16'd0, mode_q[0]};
            4'd2:    bus_rdata = {16'd0, mode_q[1]};
            4'd3:    bus_rdata = {16'd0, cnt_q[0]};
            4'd4:    bus_rdata = {16'd0, cnt_q[1]};
            4'd5:    bus_rdata = {16'd0, ref_q[0]};
            4'd6:    bus_rdata = {16'd0, ref_q[1]};
            4'd7:    bus_rdata = {16'd0, cap_q[0]};
            4'd8:    bus_rdata = {16'd0, cap_q[1]};
            4'd9:    bus_rdata = {30'd0, ev_q[0]};
            4'd10:   bus_rdata = {30'd0, ev_q[1]};
            4'd11:   bus_rdata = {cnt_q[0], cnt_q[1]};
            4'd12:   bus_rdata = {ref_q[0], ref_q[1]};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_pair_chk.sv
// Property checker for dual_timer_pair, attached by bind.
// Assumes the bound signal names of the top module.
module tmr_pair_chk (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        en,
    input logic              casc,
    input logic [1:0]        irq,
    input logic [1:0][1:0]   ev,
    input logic [1:0][1:0]   ev_clr,
    input logic [1:0][15:0]  cnt,
    input logic [1:0]        tick,
    input logic [1:0]        cnt_ld,
    input logic              gcfg_we,
    input logic [1:0]        cap_hit,
    input logic [1:0][15:0]  cap
);

    genvar ci;
    generate
        for (ci = 0; ci < 2; ci++) begin : g_chk
            AST_STOPPED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !en[ci] |=> cnt[ci] == 16'd0); // R2
            AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!casc && en[ci] && !tick[ci] && !cnt_ld[ci] && !gcfg_we) |=> $stable(cnt[ci])); // R5
            AST_CAPTURE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
                !cap_hit[ci] |=> $stable(cap[ci])); // R7
            AST_REF_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (ev[ci][0] && !ev_clr[ci][0]) |=> ev[ci][0]); // R8
            AST_CAP_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (ev[ci][1] && !ev_clr[ci][1]) |=> ev[ci][1]); // R8
            AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
                irq[ci] |-> (ev[ci] != 2'b00)); // R9
        end
    endgenerate

endmodule

bind dual_timer_pair tmr_pair_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .casc    (casc),
    .irq     (irq),
    .ev      (ev_q),
    .ev_clr  (ev_clr),
    .cnt     (cnt_q),
    .tick    (tick),
    .cnt_ld  (cnt_ld),
    .gcfg_we (gcfg_we),
    .cap_hit (cap_hit),
    .cap     (cap_q)
);

// File: tb/tb_dual_timer_pair.sv
`timescale 1ns/100ps
module tb_dual_timer_pair;

    localparam logic [3:0] A_GCFG = 4'd0, A_MODE1 = 4'd1, A_MODE2 = 4'd2,
                           A_CNT1 = 4'd3, A_CNT2 = 4'd4, A_REF1 = 4'd5, A_REF2 = 4'd6,
                           A_CAP1 = 4'd7, A_EVT1 = 4'd9, A_EVT2 = 4'd10,
                           A_CNTW = 4'd11, A_REFW = 4'd12;

    // {prescale, source, reference, expected period in clocks}
    localparam logic [47:0] VEC [0:4] = '{
        {8'd0, 2'd0, 16'd250, 22'd250},
        {8'd0, 2'd0, 16'd5,   22'd5},
        {8'd3, 2'd0, 16'd10,  22'd40},
        {8'd0, 2'd1, 16'd4,   22'd64},
        {8'd1, 2'd1, 16'd3,   22'd96}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cap_in = '0;
    logic [1:0]  irq;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    dual_timer_pair dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .irq       (irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wait_irq(input int idx, output int when);
        int w = 0;
        while (!irq[idx] && w < 5000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 5000) chk("R3 irq timeout", 32'd0, 32'd1);
        when = cyc;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int t0, t1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {30'd0, irq}, 32'd0);
        for (int a = 0; a <= 12; a++) chk_reg("R1 reg", 4'(a), 32'd0);

        // R2: stopped timer ignores count writes; unused global bits read zero
        wr(A_CNT1, 32'h55);
        chk_reg("R2 held", A_CNT1, 32'd0);
        wr(A_GCFG, 32'hFFFF_FFFF);
        chk_reg("R2 mask", A_GCFG, 32'h91);
        wr(A_GCFG, 32'h0);
        wr(A_GCFG, 32'h01);
        wr(A_MODE1, 32'h0060);
        wr(A_CNT1, 32'h55);
        chk_reg("R2 load", A_CNT1, 32'h55);
        wr(A_GCFG, 32'h0);
        @(negedge clk);
        chk_reg("R2 cleared", A_CNT1, 32'd0);

        // R3: counting from enable and restart at the reference
        wr(A_MODE1, 32'h0001);
        wr(A_REF1, 32'd250);
        wr(A_GCFG, 32'h01);
        repeat (10) @(negedge clk);
        chk_reg("R3 count", A_CNT1, 32'd10);
        repeat (240) @(negedge clk);
        chk_reg("R3 restart", A_CNT1, 32'd0);
        chk_reg("R3 event", A_EVT1, 32'd1);
        wr(A_GCFG, 32'h0);
        wr(A_EVT1, 32'hFFFF);
        chk_reg("R8 clear all", A_EVT1, 32'd0);

        // R3 R4 R5: period table on timer 2
        for (int i = 0; i < 5; i++) begin
            wr(A_GCFG, 32'h0);
            wr(A_EVT2, 32'hFFFF);
            wr(A_REF2, {16'd0, VEC[i][37:22]});
            wr(A_MODE2, {16'd0, VEC[i][47:40], 1'b0, VEC[i][39:38], 3'b000, 2'b11});
            wr(A_GCFG, 32'h10);
            wait_irq(1, t0);
            wr(A_EVT2, 32'h1);
            wait_irq(1, t1);
            chk("R3 R4 R5 period", 32'(t1 - t0), {10'd0, VEC[i][21:0]});
        end
        wr(A_GCFG, 32'h0);
        wr(A_EVT2, 32'hFFFF);

        // R6: free-running wrap past the reference
        wr(A_GCFG, 32'h01);
        wr(A_MODE1, 32'h0060);
        wr(A_CNT1, 32'hFFFD);
        wr(A_REF1, 32'h1);
        wr(A_EVT1, 32'hFFFF);
        wr(A_MODE1, 32'h0000);
        repeat (3) @(negedge clk);
        chk_reg("R6 wrap", A_CNT1, 32'd0);
        chk_reg("R6 no event yet", A_EVT1, 32'd0);
        @(negedge clk);
        chk_reg("R6 at ref", A_CNT1, 32'd1);
        chk_reg("R6 event", A_EVT1, 32'd1);
        @(negedge clk);
        chk_reg("R6 continues", A_CNT1, 32'd2);

        // R7: capture edges on timer 1 with a stopped counter
        wr(A_MODE1, 32'h0064);
        wr(A_CNT1, 32'h1234);
        wr(A_EVT1, 32'hFFFF);
        @(negedge clk);
        cap_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk_reg("R7 latency", A_CAP1, 32'd0);
        @(negedge clk);
        chk_reg("R7 rise capture", A_CAP1, 32'h1234);
        chk_reg("R7 cap event", A_EVT1, 32'd2);
        chk_reg("R5 stopped holds", A_CNT1, 32'h1234);
        wr(A_EVT1, 32'h2);
        wr(A_CNT1, 32'h2222);
        cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk_reg("R7 fall ignored", A_CAP1, 32'h1234);
        chk_reg("R7 no event", A_EVT1, 32'd0);
        wr(A_MODE1, 32'h0068);
        cap_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk_reg("R7 rise ignored", A_CAP1, 32'h1234);
        cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk_reg("R7 fall capture", A_CAP1, 32'h2222);

        // R9 R8: interrupt masking and selective clearing
        chk("R9 masked", {31'd0, irq[0]}, 32'd0);
        wr(A_MODE1, 32'h0078);
        chk("R9 enabled", {31'd0, irq[0]}, 32'd1);
        wr(A_EVT1, 32'h1);
        chk_reg("R8 zero bits kept", A_EVT1, 32'd2);
        chk("R9 still high", {31'd0, irq[0]}, 32'd1);
        wr(A_EVT1, 32'h2);
        chk_reg("R8 cleared", A_EVT1, 32'd0);
        chk("R9 dropped", {31'd0, irq[0]}, 32'd0);

        // R7: both edges
        wr(A_MODE1, 32'h006C);
        wr(A_CNT1, 32'h3333);
        cap_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk_reg("R7 both rise", A_CAP1, 32'h3333);
        wr(A_CNT1, 32'h4444);
        cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk_reg("R7 both fall", A_CAP1, 32'h4444);
        wr(A_GCFG, 32'h0);
        wr(A_EVT1, 32'hFFFF);

        // R10 R11 R12: chained pair
        wr(A_MODE2, 32'h0060);
        wr(A_MODE1, 32'h0000);
        wr(A_GCFG, 32'h91);
        wr(A_CNTW, 32'h0001_FFFE);
        chk_reg("R12 wide count", A_CNTW, 32'h0001_FFFE);
        chk_reg("R12 upper half", A_CNT1, 32'h1);
        chk_reg("R12 lower half", A_CNT2, 32'hFFFE);
        wr(A_REFW, 32'h0002_0001);
        chk_reg("R12 ref upper", A_REF1, 32'h2);
        chk_reg("R12 ref lower", A_REF2, 32'h1);
        wr(A_MODE2, 32'h0003);
        @(negedge clk);
        chk_reg("R10 step", A_CNTW, 32'h0001_FFFF);
        @(negedge clk);
        chk_reg("R10 carry", A_CNTW, 32'h0002_0000);
        chk_reg("R10 upper advanced", A_CNT1, 32'h2);
        @(negedge clk);
        chk_reg("R11 restart both", A_CNTW, 32'd0);
        chk_reg("R11 lower event", A_EVT2, 32'd1);
        chk_reg("R11 upper quiet", A_EVT1, 32'd0);
        chk("R11 irq", {30'd0, irq}, 32'd2);
        repeat (3) @(negedge clk);
        chk_reg("R11 counts on", A_CNTW, 32'd3);

        finish_run();
    end

endmodule